// File: doc/BRIEF.md
# Address-Triggered Timestamp Recorder

This block watches the address bus of a target processor and records the time at which the processor touches selected locations. The target program is not changed at all. The host programs a marker memory that is one bit wide and holds one bit per address. A set bit makes that address a measurement point. When the recorder is armed and a bus strobe presents an address whose marker bit is set, the current value of a free-running 32-bit cycle counter is pushed into a 128-entry FIFO. The host then drains the FIFO one entry per read strobe.

The host can only change marker bits while the recorder is disarmed. The host can see whether the FIFO is empty, how many entries it holds, and whether any capture was lost because the FIFO was full. The lost-capture flag stays set until reset. Reset also clears every marker bit, so a freshly reset recorder captures nothing until markers are written.

Top module: `addr_stamp_rec`

## Requirements
- R1: After reset, `empty` is 1, `count` is 0, `overflow` is 0 and every marker bit is 0, so armed strobes to any address capture nothing.
- R2: The timestamp counter is 0 in the first cycle after reset is released and adds 1 every clock. A capture stores the counter value of the cycle in which the strobe is presented.
- R3: A cycle with `bus_valid` low, or a strobe to an address whose marker bit is 0, pushes nothing.
- R4: While `arm` is 0, strobes push nothing, even to marked addresses.
- R5: A write (`mk_we` = 1) sets or clears the marker bit at `mk_addr` to `mk_bit`, but only while `arm` is 0. A write while armed is ignored.
- R6: Back-to-back strobes to the same marked address each produce their own entry.
- R7: The FIFO is first-in first-out. `rd_data` always shows the oldest entry. Each `rd` pulse removes one entry. `rd` while empty has no effect.
- R8: `count` never exceeds 128. A capture that arrives while full, with no pop in that cycle, is dropped and sets `overflow`. `overflow` stays set until reset.
- R9: A capture and a pop in the same cycle leave `count` unchanged. This holds even when the FIFO is full, and in that case the capture is kept and `overflow` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enables captures; blocks marker writes |
| mk_we | input | 1 | Marker write enable |
| mk_addr | input | ADDR_W | Marker address to write |
| mk_bit | input | 1 | Marker value to write |
| bus_valid | input | 1 | Strobe marking a valid snooped address |
| bus_addr | input | ADDR_W | Snooped target address |
| rd | input | 1 | Pop strobe |
| rd_data | output | 32 | Oldest stored timestamp |
| empty | output | 1 | FIFO holds no entry |
| count | output | 8 | Number of stored entries |
| overflow | output | 1 | Sticky flag: a capture was lost |

## Verification
Two functions can fall in the same cycle: a capture from a marked strobe and a host pop. The bench provokes this both in the middle of the FIFO and with the FIFO exactly full. It does so by asserting `rd` in the same cycle as a strobe to a marked address. It judges the result by three things: `count` staying the same, `overflow` staying clear, and the popped head and the appended timestamp both coming out in order when the FIFO is drained.

// File: rtl/addr_stamp_rec.sv
module addr_stamp_rec #(
  parameter int ADDR_W = 10,
  parameter int TS_W   = 32,
  parameter int DEPTH  = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic                     mk_we,
  input  logic [ADDR_W-1:0]        mk_addr,
  input  logic                     mk_bit,
  input  logic                     bus_valid,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     rd,
  output logic [TS_W-1:0]          rd_data,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int NMARK = 1 << ADDR_W;

  logic [NMARK-1:0] marks;
  logic [TS_W-1:0]  ts;
  logic [TS_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             hit, pop, push, full;

  assign hit   = bus_valid & arm & marks[bus_addr];
  assign empty = (count == '0);
  assign full  = (count == (PTR_W+1)'(DEPTH));
  assign pop   = rd & ~empty;
  assign push  = hit & (~full | pop);
  assign rd_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) marks <= '0;
    else if (mk_we && !arm) marks[mk_addr] <= mk_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ts <= '0;
    else ts <= ts + 1'b1;

  always_ff @(posedge clk)
    if (push) mem[wp] <= ts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
      if (hit && full && !pop) overflow <= 1'b1;
    end
endmodule

module addr_stamp_rec_chk #(
  parameter int DEPTH = 128
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm,
  input logic                   bus_valid,
  input logic                   rd,
  input logic                   hit,
  input logic                   empty,
  input logic [$clog2(DEPTH):0] count,
  input logic                   overflow
);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_disarmed_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !rd) |=> $stable(count));

  assert_idle_no_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !rd) |=> $stable(count));

  assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && empty && !hit) |=> empty);

  assert_push_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rd && !empty) |=> ($stable(count) && $stable(overflow)));
endmodule

bind addr_stamp_rec addr_stamp_rec_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .bus_valid(bus_valid), .rd(rd),
  .hit(hit), .empty(empty), .count(count), .overflow(overflow)
);

// File: tb/tb_addr_stamp_rec.sv
module tb_addr_stamp_rec;
  localparam int AW = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 1'b0, mk_we = 1'b0, mk_bit = 1'b0, bus_valid = 1'b0, rd = 1'b0;
  logic [AW-1:0] mk_addr = '0, bus_addr = '0;
  logic [31:0] rd_data;
  logic empty, overflow;
  logic [7:0] count;

  always #4 clk = ~clk;

  addr_stamp_rec #(.ADDR_W(AW), .TS_W(32), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .mk_we(mk_we), .mk_addr(mk_addr),
    .mk_bit(mk_bit), .bus_valid(bus_valid), .bus_addr(bus_addr), .rd(rd),
    .rd_data(rd_data), .empty(empty), .count(count), .overflow(overflow));

  logic [31:0] tcyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcyc <= 0; else tcyc <= tcyc + 1;

  int nvec = 0, nmis = 0;
  logic [31:0] em [1024];
  int wi = 0, ri = 0, ec = 0;
  bit eovf = 0;

  localparam logic [AW:0] VEC [12] = '{
    {1'b1, 10'd3},   {1'b0, 10'd4},   {1'b1, 10'h155}, {1'b0, 10'h2AA},
    {1'b1, 10'h3FF}, {1'b0, 10'h200}, {1'b1, 10'd0},   {1'b1, 10'd3},
    {1'b1, 10'd3},   {1'b0, 10'h154}, {1'b0, 10'h156}, {1'b1, 10'h3FF}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mark(input logic [AW-1:0] a, input logic b);
    @(negedge clk); mk_we = 1; mk_addr = a; mk_bit = b;
    @(negedge clk); mk_we = 0;
  endtask

  task automatic strobe(input logic [AW-1:0] a, input bit exp_hit, input bit do_rd, input string req);
    @(negedge clk);
    bus_valid = 1; bus_addr = a; rd = do_rd;
    if (do_rd && ec > 0) begin
      chk({req, " R7 head"}, rd_data, em[ri % 1024]);
      ri++; ec--;
    end
    if (exp_hit && arm) begin
      if (ec < DEPTH) begin em[wi % 1024] = tcyc; wi++; ec++; end
      else eovf = 1;
    end
    @(negedge clk);
    bus_valid = 0; rd = 0;
    chk({req, " count"}, 32'(count), 32'(ec));
    chk({req, " overflow"}, 32'(overflow), 32'(eovf));
  endtask

  task automatic drain(input string req);
    while (ec > 0) begin
      @(negedge clk); rd = 1;
      chk({req, " R7 R2 data"}, rd_data, em[ri % 1024]);
      ri++; ec--;
      @(negedge clk); rd = 0;
    end
    chk({req, " R7 drained"}, 32'(empty), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 count", 32'(count), 0);
    chk("R1 overflow", 32'(overflow), 0);
    arm = 1;
    strobe(10'd0, 0, 0, "R1 cleared marker 0");
    strobe(10'd3, 0, 0, "R1 cleared marker 3");
    strobe(10'h3FF, 0, 0, "R1 cleared marker top");
    arm = 0;
    mark(10'd0, 1); mark(10'd3, 1); mark(10'h155, 1);
    mark(10'h3FF, 1); mark(10'h200, 1); mark(10'h200, 0);
    @(negedge clk); arm = 1;
    mark(10'h2AA, 1);
    foreach (VEC[i]) strobe(VEC[i][AW-1:0], VEC[i][AW], 0, "R2 R3 R5 R6 table");
    @(negedge clk); bus_addr = 10'd3;
    @(negedge clk);
    chk("R3 no strobe", 32'(count), 32'(ec));
    arm = 0;
    strobe(10'd3, 0, 0, "R4 disarmed");
    arm = 1;
    strobe(10'd3, 1, 1, "R9 mid push+pop");
    drain("R7 order");
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
    chk("R7 pop empty count", 32'(count), 0);
    chk("R7 pop empty flag", 32'(empty), 1);
    for (int k = 0; k < DEPTH; k++) strobe(10'd3, 1, 0, "R8 fill");
    chk("R8 full count", 32'(count), DEPTH);
    strobe(10'd3, 1, 1, "R9 full push+pop");
    chk("R9 no overflow", 32'(overflow), 0);
    strobe(10'd3, 1, 0, "R8 drop");
    chk("R8 overflow set", 32'(overflow), 1);
    drain("R8 R9 drain");
    strobe(10'd3, 1, 0, "R8 sticky");
    chk("R8 sticky overflow", 32'(overflow), 1);
    drain("R8 final");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule